// File: doc/BRIEF.md
# Shared-Pin Parallel Bus Interface Controller

This block sits between one multiplexed 32-bit address/data bus and three users of its pins: a capture path that streams broadcast words into an external FIFO, a target path that serves remote reads and writes from a small internal register file, and a master path that runs transfers on behalf of a local requester. One sequencer owns the pins. It sets the bus direction control, keeps the PIO-in enable, the PIO-out enable and the FIFO write enable mutually exclusive, and runs the strobe/done handshake in both bus roles.

Remote cycles are framed by a strobe. A strobe taken while the address-phase marker is high carries an address. The top nibble of that address selects broadcast capture, the target register file, or nothing. A strobe taken with the marker low carries data. The local side starts a master transfer with a one-cycle start pulse. The block raises its bus request and does not touch the pins until the grant arrives. The strobe, done and grant inputs each pass through a two-flop synchronizer, and the sequencer acts only on rising edges of the synchronized strobe and done.

Top module: `shared_bus_ctrl`

## Requirements
- R1: Out of reset and while idle, the direction control is 0 (input), both PIO enables and the FIFO write enable are 0, and the strobe, done, request and local-done outputs are 0.
- R2: Of oePioIn, oePioOut and fifoWen, at most one is 1 in any cycle.
- R3: An address strobe (aleIn=1) whose bits [31:28] equal 0xB enters broadcast capture. fifoWen goes to 1 while both PIO enables stay 0. Each following data strobe (aleIn=0) gives one fifoWclk pulse, and fifoData carries that bus word.
- R4: fifoFirst is 1 with the first FIFO word after each broadcast address and 0 with every later word.
- R5: An address strobe with bits [31:28] = 0xA and wrIn=1 sets oePioIn=1 with the direction kept at input. The next data strobe stores the bus word in register [2:0] of that address, and doneOut pulses for exactly one clock.
- R6: An address strobe with bits [31:28] = 0xA and wrIn=0 sets oePioOut=1 with the direction kept at input. busAdOut presents register [2:0], and doneOut pulses once. The enable drops after the strobe falls.
- R7: An address in any other region has no effect: no enable, no doneOut, and a data strobe that follows it leaves the register file unchanged.
- R8: A local write start raises reqOut and leaves the pins undriven until grantIn. The block then drives direction 1 with oePioOut and wrOut, an address cycle (strobeOut and aleOut) and then a data cycle (strobeOut only). It waits for doneIn, then returns direction and enables to 0 and pulses doneLocal.
- R9: A local read start, once granted, drives the address with direction 1 and oePioIn. It holds strobeOut and aleOut high until doneIn rises, captures the bus word into rdData, then releases the strobe, the enable and the direction.
- R10: A master transfer that sees no doneIn rise for TIMEOUT cycles (256) releases the bus, pulses doneLocal and sets errTimeout. The next accepted start clears errTimeout.
- R11: A strobe held high for many cycles causes only one action.
- R12: A start that arrives in the same cycle as a remote address is kept pending. The remote access is served first and the master transfer follows. A start while busy is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| busAdIn | input | 32 | Address/data word seen on the bus pins |
| busAdOut | output | 32 | Address/data word the block drives |
| busDirOut | output | 1 | Bus direction control, 1 = drive |
| aleIn | input | 1 | Address-phase marker of a remote strobe |
| wrIn | input | 1 | Remote read/write flag, 1 = write |
| strobeIn | input | 1 | Remote data strobe |
| doneIn | input | 1 | Done from the remote target |
| aleOut | output | 1 | Address-phase marker of a master strobe |
| wrOut | output | 1 | Master write flag |
| strobeOut | output | 1 | Master data strobe |
| doneOut | output | 1 | One-clock done pulse in the target role |
| reqOut | output | 1 | Bus ownership request |
| grantIn | input | 1 | Bus ownership grant |
| oePioIn | output | 1 | PIO-in output enable |
| oePioOut | output | 1 | PIO-out output enable |
| fifoWen | output | 1 | Broadcast FIFO write enable |
| fifoWclk | output | 1 | FIFO write clock pulse |
| fifoFirst | output | 1 | First-word tag for the FIFO |
| fifoData | output | 32 | Word written into the FIFO |
| reqAddr | input | 32 | Local master address |
| reqWdata | input | 32 | Local master write data |
| reqWrite | input | 1 | Local master direction, 1 = write |
| reqStart | input | 1 | Local start pulse |
| busy | output | 1 | Start would be ignored |
| doneLocal | output | 1 | Master transfer ended |
| rdData | output | 32 | Data returned by a master read |
| errTimeout | output | 1 | Last master transfer timed out |

## Verification
A local start pulse and a remote address strobe can be taken by the sequencer on the same clock edge. The bench raises the remote strobe and places the start pulse two cycles later, so that it lands on the edge where the synchronized strobe edge is decoded. It then checks that the target read is answered first with the stored word and doneOut, that reqOut stays low during that answer, and that the pending master write then appears on the pins with the address given at the start. A second start sent while the write is in flight must produce no further bus activity.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_BCAST, S_TWR, S_TRD, S_MREQ, S_MWA, S_MWD, S_MWW, S_MRD
  } seqState_t;

  typedef enum logic [1:0] {DRV_NONE, DRV_MADDR, DRV_MDATA, DRV_RDREG} drvSel_t;

  typedef struct packed {
    logic    writeReg;
    logic    fetch;
    logic    latchIdx;
    logic    armTag;
    logic    fifoPush;
    logic    latchMst;
    logic    latchRd;
    drvSel_t drvSel;
  } strobes_t;
endpackage

// File: rtl/sbc_sync.sv
module sbc_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       pipe[s] <= '0;
      else if (s == 0) pipe[s] <= d;
      else             pipe[s] <= pipe[(s == 0) ? 0 : s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
  import sbc_pkg::*;
#(
  parameter int TIMEOUT = 256
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     stbS,
  input  logic     doneS,
  input  logic     grantS,
  input  logic     aleIn,
  input  logic     wrIn,
  input  logic     isBcast,
  input  logic     isTarget,
  input  logic     reqStart,
  input  logic     mstWrite,
  output strobes_t st,
  output logic     busDirOut,
  output logic     oePioIn,
  output logic     oePioOut,
  output logic     fifoWen,
  output logic     strobeOut,
  output logic     aleOut,
  output logic     wrOut,
  output logic     reqOut,
  output logic     doneOut,
  output logic     doneLocal,
  output logic     errTimeout,
  output logic     busy
);
  localparam int TMR_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT - 1);

  seqState_t state, nxt;
  logic stbPrev, donePrev, pend;
  logic [TMR_W-1:0] timer;
  logic stbRise, doneRise, addrEv, dataEv, accept, timerHit;
  logic doneEv, finEv, abortEv;

  assign stbRise  = stbS & ~stbPrev;
  assign doneRise = doneS & ~donePrev;
  assign addrEv   = stbRise & aleIn;
  assign dataEv   = stbRise & ~aleIn;
  assign busy     = (state != S_IDLE) | pend;
  assign accept   = reqStart & ~busy;
  assign timerHit = (timer == TMR_LAST);

  always_comb begin
    nxt         = state;
    st          = '0;
    st.latchMst = accept;
    doneEv      = 1'b0;
    finEv       = 1'b0;
    abortEv     = 1'b0;
    case (state)
      S_IDLE, S_BCAST: begin
        if (addrEv) begin
          if (isBcast) begin
            nxt = S_BCAST; st.armTag = 1'b1;
          end else if (isTarget && wrIn) begin
            nxt = S_TWR; st.latchIdx = 1'b1;
          end else if (isTarget) begin
            nxt = S_TRD; st.fetch = 1'b1; doneEv = 1'b1;
          end else begin
            nxt = S_IDLE;
          end
        end else if (state == S_BCAST && dataEv) begin
          st.fifoPush = 1'b1;
        end else if (state == S_IDLE && pend) begin
          nxt = S_MREQ;
        end
      end
      S_TWR: if (dataEv) begin
        st.writeReg = 1'b1; doneEv = 1'b1; nxt = S_IDLE;
      end
      S_TRD: begin
        st.drvSel = DRV_RDREG;
        if (!stbS) nxt = S_IDLE;
      end
      S_MREQ: if (grantS) nxt = mstWrite ? S_MWA : S_MRD;
      S_MWA: begin st.drvSel = DRV_MADDR; nxt = S_MWD; end
      S_MWD: begin st.drvSel = DRV_MDATA; nxt = S_MWW; end
      S_MWW: begin
        st.drvSel = DRV_MDATA;
        if (doneRise)      begin finEv = 1'b1; nxt = S_IDLE; end
        else if (timerHit) begin abortEv = 1'b1; nxt = S_IDLE; end
      end
      S_MRD: begin
        st.drvSel = DRV_MADDR;
        if (doneRise)      begin st.latchRd = 1'b1; finEv = 1'b1; nxt = S_IDLE; end
        else if (timerHit) begin abortEv = 1'b1; nxt = S_IDLE; end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      stbPrev    <= 1'b0;
      donePrev   <= 1'b0;
      pend       <= 1'b0;
      timer      <= '0;
      doneOut    <= 1'b0;
      doneLocal  <= 1'b0;
      errTimeout <= 1'b0;
    end else begin
      state     <= nxt;
      stbPrev   <= stbS;
      donePrev  <= doneS;
      doneOut   <= doneEv;
      doneLocal <= finEv | abortEv;
      if (accept)                               pend <= 1'b1;
      else if (state == S_IDLE && nxt == S_MREQ) pend <= 1'b0;
      if (abortEv)     errTimeout <= 1'b1;
      else if (accept) errTimeout <= 1'b0;
      if (state == S_MWW || state == S_MRD) timer <= timer + 1'b1;
      else                                  timer <= '0;
    end
  end

  assign fifoWen   = (state == S_BCAST);
  assign oePioIn   = (state == S_TWR) || (state == S_MRD);
  assign oePioOut  = (state == S_TRD) || (state == S_MWA) || (state == S_MWD) || (state == S_MWW);
  assign busDirOut = (state == S_MWA) || (state == S_MWD) || (state == S_MWW) || (state == S_MRD);
  assign strobeOut = (state == S_MWA) || (state == S_MWD) || (state == S_MRD);
  assign aleOut    = (state == S_MWA) || (state == S_MRD);
  assign wrOut     = (state == S_MWA) || (state == S_MWD) || (state == S_MWW);
  assign reqOut    = busDirOut || (state == S_MREQ);
endmodule

// File: rtl/sbc_dpath.sv
module sbc_dpath
  import sbc_pkg::*;
#(
  parameter int               DW            = 32,
  parameter int               NREGS         = 8,
  parameter int               REGION_W      = 4,
  parameter logic [REGION_W-1:0] BCAST_REGION  = 4'hB,
  parameter logic [REGION_W-1:0] TARGET_REGION = 4'hA
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobes_t      st,
  input  logic [DW-1:0] busAdIn,
  input  logic [DW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdata,
  input  logic          reqWrite,
  output logic [DW-1:0] busAdOut,
  output logic          isBcast,
  output logic          isTarget,
  output logic          mstWrite,
  output logic [DW-1:0] rdData,
  output logic          fifoWclk,
  output logic          fifoFirst,
  output logic [DW-1:0] fifoData
);
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [DW-1:0]    regFile [NREGS];
  logic [DW-1:0]    rdReg, mAddr, mData;
  logic [IDX_W-1:0] tgtIdx;
  logic             tagArm;

  assign isBcast  = (busAdIn[DW-1 -: REGION_W] == BCAST_REGION);
  assign isTarget = (busAdIn[DW-1 -: REGION_W] == TARGET_REGION);

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regFile[g] <= '0;
      else if (st.writeReg && tgtIdx == IDX_W'(g)) regFile[g] <= busAdIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdReg <= '0; mAddr <= '0; mData <= '0; mstWrite <= 1'b0;
      tgtIdx <= '0; tagArm <= 1'b0; rdData <= '0;
      fifoWclk <= 1'b0; fifoFirst <= 1'b0; fifoData <= '0;
    end else begin
      if (st.fetch)    rdReg  <= regFile[busAdIn[IDX_W-1:0]];
      if (st.latchIdx) tgtIdx <= busAdIn[IDX_W-1:0];
      if (st.latchMst) begin
        mAddr <= reqAddr; mData <= reqWdata; mstWrite <= reqWrite;
      end
      if (st.latchRd) rdData <= busAdIn;
      if (st.armTag)        tagArm <= 1'b1;
      else if (st.fifoPush) tagArm <= 1'b0;
      fifoWclk  <= st.fifoPush;
      fifoFirst <= st.fifoPush & tagArm;
      if (st.fifoPush) fifoData <= busAdIn;
    end
  end

  always_comb begin
    case (st.drvSel)
      DRV_MADDR: busAdOut = mAddr;
      DRV_MDATA: busAdOut = mData;
      DRV_RDREG: busAdOut = rdReg;
      default:   busAdOut = '0;
    endcase
  end
endmodule

// File: rtl/shared_bus_ctrl.sv
module shared_bus_ctrl
  import sbc_pkg::*;
#(
  parameter int DW      = 32,
  parameter int NREGS   = 8,
  parameter int TIMEOUT = 256
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] busAdIn,
  output logic [DW-1:0] busAdOut,
  output logic          busDirOut,
  input  logic          aleIn,
  input  logic          wrIn,
  input  logic          strobeIn,
  input  logic          doneIn,
  output logic          aleOut,
  output logic          wrOut,
  output logic          strobeOut,
  output logic          doneOut,
  output logic          reqOut,
  input  logic          grantIn,
  output logic          oePioIn,
  output logic          oePioOut,
  output logic          fifoWen,
  output logic          fifoWclk,
  output logic          fifoFirst,
  output logic [DW-1:0] fifoData,
  input  logic [DW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdata,
  input  logic          reqWrite,
  input  logic          reqStart,
  output logic          busy,
  output logic          doneLocal,
  output logic [DW-1:0] rdData,
  output logic          errTimeout
);
  strobes_t   st;
  logic [2:0] syncQ;
  logic       isBcast, isTarget, mstWrite;

  sbc_sync #(.W(3), .STAGES(2)) u_sync (
    .clk(clk), .rstN(rstN), .d({strobeIn, doneIn, grantIn}), .q(syncQ)
  );

  sbc_ctrl #(.TIMEOUT(TIMEOUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .stbS(syncQ[2]), .doneS(syncQ[1]), .grantS(syncQ[0]),
    .aleIn(aleIn), .wrIn(wrIn), .isBcast(isBcast), .isTarget(isTarget),
    .reqStart(reqStart), .mstWrite(mstWrite), .st(st),
    .busDirOut(busDirOut), .oePioIn(oePioIn), .oePioOut(oePioOut), .fifoWen(fifoWen),
    .strobeOut(strobeOut), .aleOut(aleOut), .wrOut(wrOut), .reqOut(reqOut),
    .doneOut(doneOut), .doneLocal(doneLocal), .errTimeout(errTimeout), .busy(busy)
  );

  sbc_dpath #(.DW(DW), .NREGS(NREGS)) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .busAdIn(busAdIn), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqWrite(reqWrite), .busAdOut(busAdOut),
    .isBcast(isBcast), .isTarget(isTarget), .mstWrite(mstWrite), .rdData(rdData),
    .fifoWclk(fifoWclk), .fifoFirst(fifoFirst), .fifoData(fifoData)
  );
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker (
  input logic clk,
  input logic rstN,
  input logic busDirOut,
  input logic oePioIn,
  input logic oePioOut,
  input logic fifoWen,
  input logic fifoWclk,
  input logic strobeOut,
  input logic wrOut,
  input logic reqOut,
  input logic doneOut,
  input logic doneLocal,
  input logic errTimeout
);
  p_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({oePioIn, oePioOut, fifoWen}));

  p_dir_owner_r1: assert property (@(posedge clk) disable iff (!rstN)
    busDirOut |-> reqOut);

  p_wclk_wen_r3: assert property (@(posedge clk) disable iff (!rstN)
    fifoWclk |-> fifoWen);

  p_target_input_r6: assert property (@(posedge clk) disable iff (!rstN)
    (oePioOut && !reqOut) |-> !busDirOut);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  p_strobe_dir_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobeOut |-> busDirOut);

  p_read_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobeOut && !wrOut) |=> (strobeOut || doneLocal));

  p_timeout_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errTimeout) |-> doneLocal);

  p_local_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    doneLocal |=> !doneLocal);
endmodule

bind shared_bus_ctrl sbc_checker u_chk (
  .clk(clk), .rstN(rstN), .busDirOut(busDirOut), .oePioIn(oePioIn),
  .oePioOut(oePioOut), .fifoWen(fifoWen), .fifoWclk(fifoWclk),
  .strobeOut(strobeOut), .wrOut(wrOut), .reqOut(reqOut), .doneOut(doneOut),
  .doneLocal(doneLocal), .errTimeout(errTimeout)
);

// File: tb/sim_shared_bus_ctrl.sv
`timescale 1ns/1ps
module sim_shared_bus_ctrl;
  logic clk = 0, rstN = 0;
  logic [31:0] busAdIn = 0, reqAddr = 0, reqWdata = 0;
  logic aleIn = 0, wrIn = 0, strobeIn = 0, doneIn = 0, grantIn = 0;
  logic reqWrite = 0, reqStart = 0;
  logic [31:0] busAdOut, fifoData, rdData;
  logic busDirOut, aleOut, wrOut, strobeOut, doneOut, reqOut;
  logic oePioIn, oePioOut, fifoWen, fifoWclk, fifoFirst;
  logic busy, doneLocal, errTimeout;

  int checks = 0, errors = 0, wclkCount = 0;
  bit finished = 0;
  logic [32:0] expFifo[$];
  int seenDone, seenOeIn, seenOeOut, seenDir, seenWen;
  logic [31:0] seenData;

  always #2.5 clk = ~clk;

  shared_bus_ctrl u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Scoreboard monitor for broadcast FIFO writes (R3, R4)
  always @(negedge clk) if (rstN && fifoWclk) begin
    logic [32:0] e;
    wclkCount++;
    checks++;
    if (expFifo.size() == 0) begin
      errors++;
      $display("FAIL R3 actual=%h expected=none", {fifoFirst, fifoData});
    end else begin
      e = expFifo.pop_front();
      if ({fifoFirst, fifoData} !== e) begin
        errors++;
        $display("FAIL R3/R4 actual=%h expected=%h", {fifoFirst, fifoData}, e);
      end
    end
  end

  task automatic busCycle(input logic ale, input logic wr, input logic [31:0] word, input int holdHi);
    seenDone = 0; seenOeIn = 0; seenOeOut = 0; seenDir = 0; seenWen = 0; seenData = 'x;
    @(negedge clk);
    busAdIn = word; aleIn = ale; wrIn = wr; strobeIn = 1;
    for (int i = 0; i < holdHi + 5; i++) begin
      if (i == holdHi) strobeIn = 0;
      @(negedge clk);
      if (doneOut) begin seenDone++; seenData = busAdOut; end
      if (oePioIn) seenOeIn++;
      if (oePioOut) seenOeOut++;
      if (busDirOut) seenDir++;
      if (fifoWen) seenWen++;
    end
  endtask

  task automatic pushExp(input logic first, input logic [31:0] d);
    expFifo.push_back({first, d});
  endtask

  task automatic startReq(input logic wr, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    reqWrite = wr; reqAddr = a; reqWdata = d; reqStart = 1;
    @(negedge clk);
    reqStart = 0;
  endtask

  task automatic finishDone();
    int n = 0;
    doneIn = 1;
    while (!doneLocal && n < 20) begin @(negedge clk); n++; end
    chk("R8 doneLocal", doneLocal, 1);
    @(negedge clk);
    doneIn = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish();
  end

  initial begin
    int n, w0, hi, rq;
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 dir", busDirOut, 0);
    chk("R1 enables", {oePioIn, oePioOut, fifoWen}, 0);
    chk("R1 handshakes", {strobeOut, doneOut, reqOut, doneLocal}, 0);

    // R3/R4 broadcast capture
    busCycle(1, 0, 32'hB000_0010, 4);
    chk("R3 fifoWen", fifoWen, 1);
    chk("R3 pio off", seenOeIn + seenOeOut, 0);
    pushExp(1, 32'h1111_0001); busCycle(0, 0, 32'h1111_0001, 4);
    pushExp(0, 32'h2222_0002); busCycle(0, 0, 32'h2222_0002, 4);
    pushExp(0, 32'h3333_0003); busCycle(0, 0, 32'h3333_0003, 4);
    busCycle(1, 0, 32'hB000_0020, 4);                         // new block re-arms tag (R4)
    pushExp(1, 32'h4444_0004); busCycle(0, 0, 32'h4444_0004, 4);
    // R11 long strobe, one write only
    w0 = wclkCount;
    pushExp(0, 32'h5555_0005); busCycle(0, 0, 32'h5555_0005, 20);
    chk("R11 single action", wclkCount - w0, 1);
    busCycle(1, 0, 32'h3000_0000, 4);                         // leave capture
    chk("R3 leave", fifoWen, 0);
    chk("R3 queue empty", expFifo.size(), 0);

    // R5 target write reg 3
    busCycle(1, 1, 32'hA000_0003, 4);
    chk("R5 oePioIn", oePioIn, 1);
    chk("R5 dir input", seenDir, 0);
    chk("R5 no done on address", seenDone, 0);
    busCycle(0, 0, 32'hDEAD_BEEF, 4);
    chk("R5 done one clock", seenDone, 1);
    chk("R5 released", oePioIn, 0);

    // R6 target read reg 3 and untouched reg 5
    busCycle(1, 0, 32'hA000_0003, 4);
    chk("R6 done one clock", seenDone, 1);
    chk("R6 data", seenData, 32'hDEAD_BEEF);
    chk("R6 oePioOut seen", seenOeOut > 0, 1);
    chk("R6 dir input", seenDir, 0);
    chk("R6 released", oePioOut, 0);
    busCycle(1, 0, 32'hA000_0005, 4);
    chk("R6 reset reg", seenData, 0);

    // R7 foreign region ignored
    busCycle(1, 1, 32'h5000_0003, 4);
    chk("R7 no enable", seenOeIn + seenOeOut + seenWen, 0);
    busCycle(0, 0, 32'h0BAD_0BAD, 4);
    chk("R7 no done", seenDone, 0);
    busCycle(1, 0, 32'hA000_0003, 4);
    chk("R7 reg kept", seenData, 32'hDEAD_BEEF);

    // R8 master write
    startReq(1, 32'h0000_0040, 32'hCAFE_0001);
    chk("R8 busy", busy, 1);
    repeat (4) @(negedge clk);
    chk("R8 request", reqOut, 1);
    chk("R8 no drive before grant", {busDirOut, strobeOut, oePioOut}, 0);
    grantIn = 1;
    n = 0;
    while (!strobeOut && n < 20) begin @(negedge clk); n++; end
    chk("R8 addr cycle", {aleOut, busDirOut, oePioOut, wrOut}, 4'hF);
    chk("R8 addr", busAdOut, 32'h0000_0040);
    @(negedge clk);
    chk("R8 data cycle", {strobeOut, aleOut}, 2'b10);
    chk("R8 data", busAdOut, 32'hCAFE_0001);
    @(negedge clk);
    chk("R8 wait", {strobeOut, busDirOut}, 2'b01);
    repeat (5) @(negedge clk);
    finishDone();
    chk("R8 no error", errTimeout, 0);
    chk("R8 released", {busDirOut, oePioOut, reqOut}, 0);

    // R9 master read
    startReq(0, 32'h0000_0080, 0);
    n = 0;
    while (!strobeOut && n < 20) begin @(negedge clk); n++; end
    chk("R9 addr", busAdOut, 32'h0000_0080);
    chk("R9 pins", {aleOut, oePioIn, busDirOut, wrOut}, 4'b1110);
    hi = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (strobeOut && aleOut) hi++; end
    chk("R9 strobe held", hi, 6);
    busAdIn = 32'h7777_1234;
    doneIn = 1;
    n = 0;
    while (!doneLocal && n < 20) begin @(negedge clk); n++; end
    chk("R9 rdData", rdData, 32'h7777_1234);
    chk("R9 released", {strobeOut, oePioIn, busDirOut}, 0);
    @(negedge clk);
    doneIn = 0; busAdIn = 0;

    // R10 timeout
    startReq(1, 32'h0000_00C0, 32'h0000_0BAD);
    n = 0;
    while (!(strobeOut && !aleOut) && n < 20) begin @(negedge clk); n++; end
    n = 0;
    while (!doneLocal && n < 400) begin @(negedge clk); n++; end
    chk("R10 window", (n >= 256 && n <= 258), 1);
    chk("R10 error", errTimeout, 1);
    chk("R10 released", {busDirOut, oePioOut}, 0);
    startReq(1, 32'h0000_0100, 32'h0000_0001);
    chk("R10 error cleared", errTimeout, 0);
    n = 0;
    while (!strobeOut && n < 20) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    finishDone();

    // R12 start in the same cycle as a remote address
    @(negedge clk);
    busAdIn = 32'hA000_0003; aleIn = 1; wrIn = 0; strobeIn = 1;
    @(negedge clk);
    @(negedge clk);
    reqStart = 1; reqWrite = 1; reqAddr = 32'h0000_0140; reqWdata = 32'h0000_ABCD;
    @(negedge clk);
    reqStart = 0;
    chk("R12 target first", {doneOut, oePioOut}, 2'b11);
    chk("R12 target data", busAdOut, 32'hDEAD_BEEF);
    chk("R12 no request yet", reqOut, 0);
    chk("R12 busy", busy, 1);
    @(negedge clk); @(negedge clk);
    strobeIn = 0;
    n = 0;
    while (!(strobeOut && aleOut) && n < 30) begin @(negedge clk); n++; end
    chk("R12 pending master addr", busAdOut, 32'h0000_0140);
    reqStart = 1; reqAddr = 32'h0000_0999;            // ignored while busy
    @(negedge clk);
    reqStart = 0;
    repeat (2) @(negedge clk);
    finishDone();
    rq = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (reqOut || strobeOut) rq++; end
    chk("R12 busy start ignored", rq, 0);
    chk("R1 idle again", {busDirOut, oePioIn, oePioOut, fifoWen}, 0);

    finish();
  end
endmodule